// File: doc/BRIEF.md
# Strobe-Driven Nine-Bit FIFO With Status Flags

This block is a first-in first-out store that sits between a data producer and a data consumer that run at their own pace. Each side drives its own active-low strobe. The producer pulses its write strobe to push a nine-bit word. The consumer pulses its read strobe to pull the oldest word onto the output. There is no address: words come out in exactly the order they went in. Up to 4096 words can be held.

All strobes are asynchronous to the block. Each one passes through a two-stage synchronizer inside a single system clock domain. Only the high-to-low transition of each synchronized strobe acts, so holding a strobe low performs a single operation.

Three active-low flags report the fill level: empty, more-than-half-full and full. An active-low master reset, sampled on the clock, clears the store. A separate active-low rewind strobe moves the read position back to the first word written since reset, so that the stored data can be read out again.

Top module: `strobe_fifo`

## Requirements
- R1: A clock edge with `mr_n` low empties the store: `empty_n`=0, `half_n`=1, `full_n`=1 and `dout`=0, and any words held before are discarded.
- R2: A falling edge of `wr_n` stores the word on `din`. It takes effect no later than the third rising clock edge after `wr_n` is sampled low. Keeping `wr_n` low longer stores no further word.
- R3: A falling edge of `rd_n` loads the oldest stored word onto `dout` and removes it from the store. Words are returned in the order they were written, and `dout` keeps that word until the next accepted read.
- R4: A write while 4096 words are stored is ignored: the stored words and their number do not change.
- R5: A read while the store is empty is ignored: `dout` keeps its previous value and `empty_n` stays 0.
- R6: `half_n` is 0 exactly when 2049 or more words are stored. With 2048 words it is 1.
- R7: `full_n` is 0 exactly when 4096 words are stored, and `empty_n` is 0 exactly when none are. The stored count never exceeds 4096.
- R8: A falling edge of `rt_n` moves the read position to the first word written since reset and leaves the write position as it is. Later reads replay the data from that word onward. This holds while no more than 4096 words have been written since reset. A read strobe in the same cycle as the rewind is ignored.
- R9: A write and a read detected in the same clock cycle, with the store neither empty nor full, are both carried out and leave the stored count unchanged.
- R10: A write and a read detected in the same cycle on an empty store perform the write only. `dout` keeps its value and the store then holds one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register updates on its rising edge |
| mr_n | input | 1 | Master reset, active low, sampled on the clock |
| wr_n | input | 1 | Write strobe, active low, asynchronous; its falling edge stores `din` |
| rd_n | input | 1 | Read strobe, active low, asynchronous; its falling edge loads the next word |
| rt_n | input | 1 | Rewind strobe, active low, asynchronous; its falling edge restarts reading from the first word |
| din | input | 9 | Word to be stored |
| dout | output | 9 | Most recently read word |
| empty_n | output | 1 | Low when no words are stored |
| half_n | output | 1 | Low when more than half of the capacity is in use |
| full_n | output | 1 | Low when every location holds a word |

## Verification
On every cycle the assertions check the following: the stored count stays within capacity, a refused write leaves the write position still, and a refused read leaves both the read position and `dout` unchanged. They also check that a rewind lands on the first location, that a paired read and write keep the count, and that the flags never contradict each other. Several behaviours can only be shown by the bench scenarios, because they depend on data written long before. These are the exact order of the words through a complete fill and drain, the flag thresholds at 2048/2049 and 4095/4096 words, the replay of data after a rewind, and the fact that an overflow write leaves no trace once the store is drained.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int unsigned DEF_DATA_W = 9;
    localparam int unsigned DEF_DEPTH  = 4096;
    localparam int unsigned DEF_SYNC   = 2;

    // index of each strobe inside the synchronizer bank
    typedef enum int unsigned {
        STB_WRITE  = 0,
        STB_READ   = 1,
        STB_REWIND = 2,
        STB_COUNT  = 3
    } strobe_idx_e;

    // one-cycle events produced from the strobes
    typedef struct packed {
        logic write;
        logic read;
        logic rewind;
    } strobe_ev_t;

    // active-high view of the fill state
    typedef struct packed {
        logic empty;
        logic half;
        logic full;
    } fill_flags_t;

    function automatic fill_flags_t flags_from_count(input int unsigned cnt,
                                                     input int unsigned depth);
        fill_flags_t f;
        f.empty = (cnt == 0);
        f.half  = (cnt >= depth / 2 + 1);
        f.full  = (cnt >= depth);
        return f;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_lane
            // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
            logic [STAGES:0] chain;

            always_ff @(posedge clk) begin
                if (!mr_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-1:0], strobe_n[g]};
                end
            end

            assign fall[g] = chain[STAGES] & ~chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned DEPTH  = 4096,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              mr_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!mr_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          mr_n,
    input  strobe_ev_t    ev,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output fill_flags_t   flags
);

    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [PW-1:0] count;

    assign count = wptr - rptr;
    assign flags = flags_from_count(int'(count), DEPTH);

    // acceptance uses the state before this cycle; a rewind overrides a read
    assign wr_ok = ev.write && !flags.full;
    assign rd_ok = ev.read && !flags.empty && !ev.rewind;

    assign waddr = wptr[AW-1:0];
    assign raddr = rptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (!mr_n) begin
            wptr <= '0;
        end else if (wr_ok) begin
            wptr <= wptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!mr_n) begin
            rptr <= '0;
        end else if (ev.rewind) begin
            rptr <= '0;
        end else if (rd_ok) begin
            rptr <= rptr + PW'(1);
        end
    end

    // R7: the count stays within capacity
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!mr_n)
        count <= FULL_CNT);

    // R4: a write on a full store leaves the write position unchanged
    a_r4_full_write_blocked: assert property (@(posedge clk) disable iff (!mr_n)
        (ev.write && count == FULL_CNT) |=> $stable(wptr));

    // R5: a read on an empty store leaves the read position unchanged
    a_r5_empty_read_blocked: assert property (@(posedge clk) disable iff (!mr_n)
        (ev.read && !ev.rewind && count == '0) |=> $stable(rptr));

    // R8: a rewind lands on the first location and keeps the write position
    a_r8_rewind_start: assert property (@(posedge clk) disable iff (!mr_n)
        (ev.rewind && !ev.write) |=> (rptr == '0 && $stable(wptr)));

    // R9: a paired read and write keep the count
    a_r9_pair_keeps_count: assert property (@(posedge clk) disable iff (!mr_n)
        (ev.write && ev.read && !ev.rewind && count != '0 && count != FULL_CNT)
        |=> (count == $past(count)));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned SYNC   = DEF_SYNC,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              mr_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              empty_n,
    output logic              half_n,
    output logic              full_n
);

    localparam int unsigned NS = int'(STB_COUNT);

    logic [NS-1:0] strobes_n;
    logic [NS-1:0] falls;
    strobe_ev_t    ev;
    fill_flags_t   flags;
    logic          wr_ok;
    logic          rd_ok;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    always_comb begin
        strobes_n             = '1;
        strobes_n[STB_WRITE]  = wr_n;
        strobes_n[STB_READ]   = rd_n;
        strobes_n[STB_REWIND] = rt_n;
    end

    strobe_edge #(
        .N      (NS),
        .STAGES (SYNC)
    ) u_edge (
        .clk      (clk),
        .mr_n     (mr_n),
        .strobe_n (strobes_n),
        .fall     (falls)
    );

    always_comb begin
        ev.write  = falls[STB_WRITE];
        ev.read   = falls[STB_READ];
        ev.rewind = falls[STB_REWIND];
    end

    fifo_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk   (clk),
        .mr_n  (mr_n),
        .ev    (ev),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .waddr (waddr),
        .raddr (raddr),
        .flags (flags)
    );

    fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .mr_n  (mr_n),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (din),
        .re    (rd_ok),
        .raddr (raddr),
        .rdata (dout)
    );

    assign empty_n = ~flags.empty;
    assign half_n  = ~flags.half;
    assign full_n  = ~flags.full;

    // R5: an ignored read leaves the output word alone
    a_r5_dout_holds: assert property (@(posedge clk) disable iff (!mr_n)
        (ev.read && !empty_n) |=> $stable(dout));

    // R6 / R7: the flags never contradict each other
    a_r6_half_not_empty: assert property (@(posedge clk) disable iff (!mr_n)
        !half_n |-> empty_n);

    a_r7_full_not_empty: assert property (@(posedge clk) disable iff (!mr_n)
        !full_n |-> (empty_n && !half_n));

endmodule

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  DEPTH      = 4096;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       mr_n = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       empty_n;
    logic       half_n;
    logic       full_n;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strobe_fifo uut (
        .clk     (clk),
        .mr_n    (mr_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .rt_n    (rt_n),
        .din     (din),
        .dout    (dout),
        .empty_n (empty_n),
        .half_n  (half_n),
        .full_n  (full_n)
    );

    function automatic logic [8:0] pattern(input int i);
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; mr_n = 1'b0;
        repeat (3) @(negedge clk);
        mr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // one strobe pulse: 4 cycles low, 4 cycles high; sampled at a falling clock edge afterwards
    task automatic op(input bit w, input bit r, input bit t, input logic [8:0] d);
        @(negedge clk);
        din = d; wr_n = ~w; rd_n = ~r; rt_n = ~t;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(empty_n == 1'b0, "R1 empty after reset", int'(empty_n), 0);
        check(half_n == 1'b1,  "R1 half after reset",  int'(half_n), 1);
        check(full_n == 1'b1,  "R1 full after reset",  int'(full_n), 1);
        check(dout == 9'h000,  "R1 dout after reset",  int'(dout), 0);
        op(1, 0, 0, 9'h0AA);
        op(1, 0, 0, 9'h055);
        do_reset();
        check(empty_n == 1'b0, "R1 reset discards words", int'(empty_n), 0);
        op(1, 0, 0, 9'h123);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h123, "R1 first word after reset", int'(dout), 'h123);
    endtask

    task automatic t_order();
        do_reset();
        op(1, 0, 0, 9'h1A5);
        check(empty_n == 1'b1, "R2 write clears empty", int'(empty_n), 1);
        // timing: strobe low, third rising edge must already have stored it
        @(negedge clk);
        din = 9'h05A; wr_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        op(1, 0, 0, 9'h100);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h1A5, "R3 order word 0", int'(dout), 'h1A5);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h05A, "R2 short write stored", int'(dout), 'h05A);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h100, "R3 order word 2", int'(dout), 'h100);
        check(empty_n == 1'b0, "R7 empty after drain", int'(empty_n), 0);
        // long low write: only one word
        @(negedge clk);
        din = 9'h077; wr_n = 1'b0;
        repeat (20) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h077, "R2 long write word", int'(dout), 'h077);
        check(empty_n == 1'b0, "R2 long write stores one", int'(empty_n), 0);
    endtask

    task automatic t_empty_read();
        op(0, 1, 0, 9'h000);
        check(dout == 9'h077,  "R5 dout holds on empty read", int'(dout), 'h077);
        check(empty_n == 1'b0, "R5 still empty", int'(empty_n), 0);
    endtask

    task automatic t_simul();
        do_reset();
        op(1, 0, 0, 9'h0A1);
        op(1, 1, 0, 9'h0B2);
        check(dout == 9'h0A1,  "R9 pair reads oldest", int'(dout), 'h0A1);
        check(empty_n == 1'b1, "R9 pair keeps one word", int'(empty_n), 1);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h0B2,  "R9 pair wrote word", int'(dout), 'h0B2);
        check(empty_n == 1'b0, "R9 empty after", int'(empty_n), 0);
        op(1, 1, 0, 9'h0C3);
        check(dout == 9'h0B2,  "R10 read ignored on empty", int'(dout), 'h0B2);
        check(empty_n == 1'b1, "R10 write done on empty", int'(empty_n), 1);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h0C3,  "R10 stored word", int'(dout), 'h0C3);
        check(empty_n == 1'b0, "R10 one word only", int'(empty_n), 0);
    endtask

    task automatic t_rewind();
        do_reset();
        for (int i = 0; i < 5; i++) op(1, 0, 0, pattern(i + 100));
        op(0, 1, 0, 9'h000);
        op(0, 1, 0, 9'h000);
        check(dout == pattern(101), "R3 before rewind", int'(dout), int'(pattern(101)));
        op(0, 0, 1, 9'h000);
        check(dout == pattern(101), "R8 rewind keeps dout", int'(dout), int'(pattern(101)));
        for (int i = 0; i < 5; i++) begin
            op(0, 1, 0, 9'h000);
            check(dout == pattern(i + 100), "R8 replay", int'(dout), int'(pattern(i + 100)));
        end
        check(empty_n == 1'b0, "R8 write position kept", int'(empty_n), 0);
        op(1, 0, 0, 9'h1EE);
        op(0, 1, 0, 9'h000);
        check(dout == 9'h1EE, "R8 next write after rewind", int'(dout), 'h1EE);
    endtask

    task automatic t_fill();
        int bad;
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            op(1, 0, 0, pattern(i));
            if (i == 2047) check(half_n == 1'b1, "R6 half at 2048", int'(half_n), 1);
            if (i == 2048) check(half_n == 1'b0, "R6 half at 2049", int'(half_n), 0);
            if (i == 4094) check(full_n == 1'b1, "R7 not full at 4095", int'(full_n), 1);
        end
        check(full_n == 1'b0, "R7 full at 4096", int'(full_n), 0);
        check(half_n == 1'b0, "R6 half when full", int'(half_n), 0);
        op(1, 0, 0, 9'h1FF);
        check(full_n == 1'b0, "R4 still full", int'(full_n), 0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            op(0, 1, 0, 9'h000);
            if (dout != pattern(i)) bad++;
            if (i == 0) check(full_n == 1'b1, "R7 full clears", int'(full_n), 1);
            if (i == 2046) check(half_n == 1'b0, "R6 half at 2049 drain", int'(half_n), 0);
            if (i == 2047) check(half_n == 1'b1, "R6 half at 2048 drain", int'(half_n), 1);
        end
        check(bad == 0, "R3 full drain order", bad, 0);
        check(empty_n == 1'b0, "R4 overflow write left nothing", int'(empty_n), 0);
        check(dout == pattern(DEPTH - 1), "R4 last word intact", int'(dout), int'(pattern(DEPTH - 1)));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_simul();
        t_rewind();
        t_fill();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule